// File: doc/BRIEF.md
# Synchronous Burst SRAM Address Sequencer

This block is the address and control front end of a synchronous flow-through burst SRAM. It takes an external address and three chip enables, but loads them only on a clock edge where one of two address strobes is active. One strobe serves a processor and the other serves a cache controller. The captured upper address bits stay fixed for the whole burst. The low two bits come from a beat counter that restarts at zero on each load. The counter steps by one on every edge where the advance input is active, and it wraps inside its group of four beats. The result is the common 2-1-1-1 access profile: the first beat comes from the strobe, and each later beat costs one clock.

A static order input chooses how the beat count maps onto the low address bits. When it is high, the order is interleaved: the start bits are XORed with the beat count. When it is low, the order is linear: the beat count is added to the start bits, modulo four. The block also decodes a global write, a byte-write enable and one strobe per byte lane into a registered per-lane write mask. A cycle that writes no lane counts as a read. The output enable is not registered; it gates the read-drive indication directly.

Top module: `burst_addr_seq`

## Requirements
- R1: During synchronous active-low reset, and on the first cycle after it, mem_addr is 0, sel is 0, wr_mask is 0, rd_en is 0 and drive_en is 0.
- R2: On a rising edge where strobe_c_n is 0, or where strobe_p_n is 0 and ce_n is 0, the block loads addr_in and sets the beat count to 0. From the next cycle, mem_addr equals the loaded address. On the same edge, sel becomes 1 exactly when ce_n=0, ce2=1 and ce3_n=0.
- R3: On an edge with no load, changes on addr_in, ce_n, ce2 and ce3_n have no effect on mem_addr or sel.
- R4: When strobe_p_n=0 and ce_n=1 on an edge where strobe_c_n=1, the processor strobe is ignored: the loaded address and sel are kept.
- R5: When strobe_c_n=0, a load happens whatever strobe_p_n and ce_n are, and this includes a deselecting load (sel becomes 0) when ce_n=1.
- R6: On an edge with no load, adv_n=0 moves the beat count forward by one, modulo 4. With adv_n=1, the beat count is held.
- R7: With order_il=1, mem_addr[1:0] equals the start low bits XOR the beat count.
- R8: With order_il=0, mem_addr[1:0] equals (start low bits + beat count) mod 4, wrapping within the group of four.
- R9: mem_addr[ADDR_W-1:2] stays at the loaded value throughout a burst.
- R10: On an edge with gw_n=0, the registered write mask becomes all ones. From the next cycle, wr_mask shows that value while sel=1.
- R11: On an edge with gw_n=1 and bwe_n=0, the mask becomes the bitwise inverse of bw_n, with bit i being lane i. With gw_n=1 and bwe_n=1, the mask becomes 0. wr_mask is 0 whenever sel=0. rd_en is 1 when sel=1 and the mask is 0.
- R12: drive_en equals rd_en AND NOT oe_n, and it follows oe_n without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | External address |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Depth-expansion enable, active high |
| ce3_n | input | 1 | Depth-expansion enable, active low |
| strobe_p_n | input | 1 | Processor address strobe, active low |
| strobe_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_il | input | 1 | 1 selects interleaved order, 0 selects linear order |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane byte strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| mem_addr | output | ADDR_W | Internal array address |
| sel | output | 1 | Device selected by the last load |
| wr_mask | output | LANES | Per-lane write mask for the current beat |
| rd_en | output | 1 | Current beat is a read |
| drive_en | output | 1 | Read data may be driven |

## Verification
The assertions assume that every synchronous input is stable across the rising edge. They also assume that order_il changes only between bursts, because the address mapping reads that input directly. The stimulus drives all inputs one time unit after the falling edge and changes order_il only while the strobes are idle. The only input changed in the middle of a cycle is oe_n. The reference model in the bench is updated on each rising edge and compared with the outputs on each falling edge.

// File: rtl/bsq_pkg.sv
// Shared types for the burst address sequencer.
// Assumes: the order selection is a static pin held between bursts.
package bsq_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/bsq_addr_capture.sv
// Loads the external address and the chip-select result when an address
// strobe qualifies. The controller strobe always loads. The processor strobe
// loads only while the primary enable input is active.
// Assumes: every strobe and enable here is already active high.
module bsq_addr_capture #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sp_act,
    input  logic              sc_act,
    input  logic              ce_act,
    input  logic              ce2_act,
    input  logic              ce3_act,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              load,
    output logic [ADDR_W-1:0] base_q,
    output logic              sel_q
);
    logic sel_next;

    // Load qualification: the controller strobe wins; the processor strobe needs the enable.
    always_comb begin
        load     = sc_act | (sp_act & ce_act);
        sel_next = ce_act & ce2_act & ce3_act;
    end

    // Address and selection registers, updated only on a qualified load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            sel_q  <= 1'b0;
        end else if (load) begin
            base_q <= addr_in;
            sel_q  <= sel_next;
        end
    end

    // R2
    base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> base_q == $past(addr_in));

    // R3
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(base_q) && $stable(sel_q));

    // R4
    psel_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_act && !ce_act && !sc_act) |=> $stable(sel_q));
endmodule

// File: rtl/bsq_burst_counter.sv
// Beat counter and order mapping. It restarts at zero on a load, steps on
// advance, and wraps inside its power-of-two group. The low address bits come
// from the start bits and the count, either by XOR or by modular addition.
// Assumes: load takes priority over advance in the same cycle.
module bsq_burst_counter #(
    parameter int CNT_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  adv,
    input  logic [CNT_W-1:0]      start_lo,
    input  bsq_pkg::burst_order_e order,
    output logic [CNT_W-1:0]      low
);
    localparam int BEATS = 1 << CNT_W;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Beat count: clear on load, step on advance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Order mapping from the start bits and the beat count.
    always_comb begin
        if (order == bsq_pkg::ORD_INTERLEAVE) low = start_lo ^ cnt_q;
        else                                  low = start_lo + cnt_q;
    end

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(cnt_q));

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R2
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == '0);
endmodule

// File: rtl/bsq_write_decode.sv
// Turns global write, byte-write enable and the per-lane strobes into a
// registered lane mask. Global write covers every lane. The byte-write enable
// covers only the lanes whose strobes are active.
// Assumes: all inputs are already active high.
module bsq_write_decode #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gw_act,
    input  logic             bwe_act,
    input  logic [LANES-1:0] bw_act,
    output logic [LANES-1:0] wr_q
);
    logic [LANES-1:0] lane_next;

    // One decode per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb lane_next[g] = gw_act | (bwe_act & bw_act[g]);
    end

    // The mask register samples the decode on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= lane_next;
    end

    // R10
    gw_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gw_act |=> &wr_q);

    // R11
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gw_act && !bwe_act) |=> wr_q == '0);
endmodule

// File: rtl/burst_addr_seq.sv
// Top of the burst SRAM address sequencer. It converts the active-low pins,
// joins the captured upper address with the mapped beat bits, gates the
// write mask with the selection, and gates the read indication with the
// output enable outside any register.
// Assumes: synchronous inputs are stable around the rising edge.
module burst_addr_seq #(
    parameter int ADDR_W = 18,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              strobe_p_n,
    input  logic              strobe_c_n,
    input  logic              adv_n,
    input  logic              order_il,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              sel,
    output logic [LANES-1:0]  wr_mask,
    output logic              rd_en,
    output logic              drive_en
);
    localparam int CNT_W = 2;
    localparam int UP_W  = ADDR_W - CNT_W;

    logic                  load;
    logic [ADDR_W-1:0]     base_q;
    logic                  sel_q;
    logic [CNT_W-1:0]      low;
    logic [LANES-1:0]      wr_q;
    bsq_pkg::burst_order_e order;

    // Static order pin as the enum type.
    always_comb order = order_il ? bsq_pkg::ORD_INTERLEAVE : bsq_pkg::ORD_LINEAR;

    bsq_addr_capture #(.ADDR_W(ADDR_W)) i_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .sp_act  (!strobe_p_n),
        .sc_act  (!strobe_c_n),
        .ce_act  (!ce_n),
        .ce2_act (ce2),
        .ce3_act (!ce3_n),
        .addr_in (addr_in),
        .load    (load),
        .base_q  (base_q),
        .sel_q   (sel_q)
    );

    bsq_burst_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (!adv_n),
        .start_lo (base_q[CNT_W-1:0]),
        .order    (order),
        .low      (low)
    );

    bsq_write_decode #(.LANES(LANES)) i_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .gw_act  (!gw_n),
        .bwe_act (!bwe_n),
        .bw_act  (~bw_n),
        .wr_q    (wr_q)
    );

    // Output assembly: fixed upper bits, mapped beat bits, selection gating, async enable.
    always_comb begin
        mem_addr = {base_q[ADDR_W-1:CNT_W], low};
        sel      = sel_q;
        wr_mask  = sel_q ? wr_q : '0;
        rd_en    = sel_q & ~(|wr_q);
        drive_en = rd_en & ~oe_n;
    end

    // R9
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mem_addr[ADDR_W-1:CNT_W]));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv_n && $stable(order_il)) |=> $stable(mem_addr));

    // R11
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (wr_mask == '0 && !rd_en && !drive_en));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!sel && mem_addr == '0 && wr_mask == '0));

    logic [UP_W-1:0] unused_up;
    always_comb unused_up = base_q[ADDR_W-1:CNT_W];
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
    localparam int AW = 18;
    localparam int NL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic ce_n = 1'b1, ce2 = 1'b1, ce3_n = 1'b0;
    logic strobe_p_n = 1'b1, strobe_c_n = 1'b1, adv_n = 1'b1, order_il = 1'b0;
    logic gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b1;
    logic [NL-1:0] bw_n = '1;
    logic [AW-1:0] mem_addr;
    logic sel, rd_en, drive_en;
    logic [NL-1:0] wr_mask;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // reference model state
    int m_base = 0, m_k = 0, m_wr = 0;
    bit m_sel = 0;

    burst_addr_seq #(.ADDR_W(AW), .LANES(NL)) i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .ce_n(ce_n), .ce2(ce2),
        .ce3_n(ce3_n), .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
        .adv_n(adv_n), .order_il(order_il), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .oe_n(oe_n), .mem_addr(mem_addr), .sel(sel),
        .wr_mask(wr_mask), .rd_en(rd_en), .drive_en(drive_en)
    );

    always #10 clk = ~clk;

    function automatic int exp_addr();
        int lo = m_base % 4;
        int b;
        if (order_il) b = lo ^ m_k;
        else          b = (lo + m_k) % 4;
        return (m_base / 4) * 4 + b;
    endfunction

    // model update on the rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = 0; m_k = 0; m_sel = 0; m_wr = 0;
        end else begin
            if (!strobe_c_n || (!strobe_p_n && !ce_n)) begin
                m_base = int'(addr_in); m_k = 0;
                m_sel  = !ce_n && ce2 && !ce3_n;
            end else if (!adv_n) begin
                m_k = (m_k + 1) % 4;
            end
            if (!gw_n)       m_wr = 15;
            else if (!bwe_n) m_wr = int'(~bw_n) & 15;
            else             m_wr = 0;
        end
    end

    task automatic compare();
        int ea = exp_addr();
        int em = m_sel ? m_wr : 0;
        bit er = m_sel && (m_wr == 0);
        bit ed = er && !oe_n;
        checks++;
        if (int'(mem_addr) != ea) begin
            errors++; $display("FAIL %s mem_addr got %h exp %h", tag, mem_addr, ea);
        end
        checks++;
        if (sel != m_sel) begin
            errors++; $display("FAIL %s sel got %0b exp %0b", tag, sel, m_sel);
        end
        checks++;
        if (int'(wr_mask) != em || rd_en != er || drive_en != ed) begin
            errors++;
            $display("FAIL %s wr_mask/rd/drv got %h/%0b/%0b exp %h/%0b/%0b",
                     tag, wr_mask, rd_en, drive_en, em, er, ed);
        end
    endtask

    // comparison on every falling edge
    always @(negedge clk) compare();

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic idle();
        strobe_p_n = 1; strobe_c_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = '1;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog got timeout exp completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        tag = "R1";
        repeat (3) step();
        rst_n = 1; step();
        // R2 controller-strobe load, selected
        tag = "R2";
        addr_in = 18'h12345; ce_n = 0; ce2 = 1; ce3_n = 0; strobe_c_n = 0; step();
        idle(); step();
        // R3 no strobe: address and enables ignored
        tag = "R3";
        addr_in = 18'h3FFFF; ce_n = 1; ce2 = 0; step(); step();
        // R7 interleaved from start bits 2, with one hold beat for R6
        tag = "R7";
        order_il = 1; addr_in = 18'h0ABC6; ce_n = 0; ce2 = 1; strobe_p_n = 0; step();
        idle(); adv_n = 0; step(); step();
        tag = "R6"; adv_n = 1; step(); step();
        tag = "R7"; adv_n = 0; step(); step(); step();
        // R8 linear from start bits 3, wraps; R9 upper bits stay put
        tag = "R8"; idle(); step();
        order_il = 0; addr_in = 18'h2D5A3; strobe_c_n = 0; step();
        idle(); adv_n = 0;
        tag = "R9"; addr_in = 18'h00000;
        for (int i = 0; i < 5; i++) step();
        // R4 processor strobe with primary enable high is ignored
        tag = "R4"; idle(); ce_n = 1; strobe_p_n = 0; addr_in = 18'h11111; step(); step();
        // R5 both strobes with enable high: controller loads and deselects
        tag = "R5"; strobe_c_n = 0; addr_in = 18'h22222; step();
        idle(); step();
        ce_n = 0; strobe_p_n = 0; addr_in = 18'h33330; step();
        // R10 global write covers all lanes
        tag = "R10"; idle(); gw_n = 0; bwe_n = 0; bw_n = 4'b1111; step();
        // R11 byte lanes 0 and 2
        tag = "R11"; gw_n = 1; bwe_n = 0; bw_n = 4'b1010; step();
        bw_n = 4'b1111; step();
        bwe_n = 1; bw_n = 4'b0000; step();
        // R12 output enable acts without a clock
        tag = "R12"; oe_n = 0; #2; compare(); oe_n = 1; #2; compare(); oe_n = 0; step();
        // mixed traffic
        tag = "mixed";
        for (int i = 0; i < 300; i++) begin
            addr_in = AW'($urandom); ce_n = $urandom_range(0, 3) == 0; ce2 = $urandom_range(0, 7) != 0;
            ce3_n = $urandom_range(0, 7) == 0; strobe_p_n = $urandom_range(0, 3) != 0;
            strobe_c_n = $urandom_range(0, 3) != 0; adv_n = $urandom_range(0, 1);
            gw_n = $urandom_range(0, 5) != 0; bwe_n = $urandom_range(0, 1); bw_n = NL'($urandom);
            oe_n = $urandom_range(0, 1);
            if (strobe_p_n && strobe_c_n && (i % 16 == 0)) order_il = ~order_il;
            step();
        end
        idle(); step();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule